// File: doc/BRIEF.md
# Half-Range Wrap-Around Match Comparator

This block watches a free-running timebase counter and fires once that counter reaches or passes a programmed target. Counter and target are both `CNT_W` bits wide and wrap around. The comparison is "greater than or equal" under modular arithmetic, limited to a window of half the counter range. A target that lies up to half a range behind the counter is stale, and it fires at the first comparison after the write. A target that lies ahead of the counter, up to and including half a range ahead, waits until the counter reaches it.

Each write to the match register arms the unit with:
- a target time, and
- a pin level to apply when the match fires.

When the match is detected, the unit does four things on the same clock edge:
- drives the pin to the stored level;
- captures the counter value as the event time;
- raises a one-clock match pulse;
- disarms itself.

The event time is the counter value at detection. The match time is the value that was written. The two differ whenever a stale target fires late.

A scheduler outside the block supplies the counter and writes successive targets. It builds intervals longer than half a range by chaining several targets that carry the same pin level.

Top module: `hrmatch_top`

## Requirements
- R1: While reset is asserted and after it is released, `match_o` is 0, `pin_o` equals the `PIN_INIT` parameter (default 0), and `event_time_o` and `match_time_o` are 0.
- R2: A write (`wr_i` high at a rising edge) loads `wr_time_i` into the target. From that edge onward `match_time_o` shows the written value.
- R3: The target is armed after a write. A match is detected at any later rising edge where the target is still armed and `(cnt_i - target) mod 2^CNT_W` is below `2^(CNT_W-1)`, with neither `wr_i` nor `cancel_i` high. `match_o` is high for the clock cycle that follows the detecting edge.
- R4: A target ahead of the counter does not fire early. It fires at the first edge where `cnt_i` equals the target.
- R5: A stale target fires at the first edge after the write. A target is stale when it lies at most `2^(CNT_W-1)-1` counts behind the counter sampled at that edge.
- R6: Both ends of the window behave exactly as stated. A difference of `0x7FFF` at 16 bits fires. A difference of `0x8000` (target exactly half a range ahead) does not fire until the counter reaches the target.
- R7: At a match, `event_time_o` takes the `cnt_i` value of the detecting edge, which may differ from `match_time_o`. For example, with the counter at `0x6000` and `0x5E00` written, the event time is `0x6000`. `event_time_o` changes at no other time.
- R8: At a match, `pin_o` takes the level given with the write (1 = high, 0 = low). `pin_o` holds its level at every other edge.
- R9: Each write produces at most one match. After firing, the unit stays disarmed until the next write, so `match_o` is never high for two consecutive cycles.
- R10: A new write replaces any pending target. The replaced target never fires, and no match is detected at the edge of the write.
- R11: A cancel (`cancel_i` high, `wr_i` low) disarms the pending target without changing `pin_o`. When `wr_i` and `cancel_i` are high together, the write wins and the new target is armed.
- R12: The comparison works across counter wrap. A target just past the all-ones value fires only after the counter wraps through zero and reaches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | CNT_W | Free-running timebase value |
| wr_i | input | 1 | Match-register write strobe |
| wr_time_i | input | CNT_W | Target time to load |
| wr_level_i | input | 1 | Pin level to apply at the match |
| cancel_i | input | 1 | Disarm the pending target |
| match_o | output | 1 | One-cycle match pulse |
| pin_o | output | 1 | Output pin level |
| event_time_o | output | CNT_W | Counter value captured at the last match |
| match_time_o | output | CNT_W | Last written target time |

## Verification
The assertions assume that `cnt_i`, `wr_i`, `wr_time_i`, `wr_level_i` and `cancel_i` are stable around each rising edge. They also assume that a write or cancel is a single-cycle strobe; nothing further is assumed about how the counter moves. The stimulus changes every input only on the falling edge. It advances the counter by one per cycle while a target is pending, and jumps the counter only when the unit is idle, so every expected event time and cycle follows from the written target. The boundary cases are placed at fixed counter values: a difference of exactly `0x7FFF` and of exactly `0x8000`, the wrap through zero, and the stale-target example.

// File: rtl/hrmatch_pkg.sv
package hrmatch_pkg;

   // Selects how the half-range "counter at or past target" test is built.
   // CMP_SUB : full-width subtraction, then compare against the half range.
   // CMP_SPLIT : compare the low bits alone; the top bit of the difference is
   //             then the XOR of both top bits and the low-part borrow.
   typedef enum logic [0:0] {
      CMP_SUB   = 1'b0,
      CMP_SPLIT = 1'b1
   } cmp_style_e;

endpackage

// File: rtl/hrmatch_wrap_ge.sv
module hrmatch_wrap_ge
   import hrmatch_pkg::*;
#(
   parameter int         CNT_W = 16,
   parameter cmp_style_e STYLE = CMP_SUB
) (
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] target_i,
   output logic             hit_o
);

   localparam logic [CNT_W-1:0] HALF = {1'b1, {(CNT_W-1){1'b0}}};

   generate
      if (STYLE == CMP_SUB) begin : g_sub
         logic [CNT_W-1:0] diff;
         assign diff  = cnt_i - target_i;
         assign hit_o = (diff < HALF);
      end else begin : g_split
         logic borrow_lo;
         assign borrow_lo = (cnt_i[CNT_W-2:0] < target_i[CNT_W-2:0]);
         assign hit_o     = ~(cnt_i[CNT_W-1] ^ target_i[CNT_W-1] ^ borrow_lo);
      end
   endgenerate

endmodule

// File: rtl/hrmatch_arm_ctl.sv
module hrmatch_arm_ctl #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [CNT_W-1:0] wr_time_i,
   input  logic             wr_level_i,
   input  logic             cancel_i,
   input  logic             fire_i,
   output logic             armed_o,
   output logic [CNT_W-1:0] target_o,
   output logic             level_o
);

   logic             armed_q;
   logic [CNT_W-1:0] target_q;
   logic             level_q;
   logic             armed_d;

   // Write has top priority, then cancel and firing both disarm.
   always_comb begin
      armed_d = armed_q;
      if (wr_i)
         armed_d = 1'b1;
      else if (cancel_i || fire_i)
         armed_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q  <= 1'b0;
         target_q <= '0;
         level_q  <= 1'b0;
      end else begin
         armed_q <= armed_d;
         if (wr_i) begin
            target_q <= wr_time_i;
            level_q  <= wr_level_i;
         end
      end
   end

   assign armed_o  = armed_q;
   assign target_o = target_q;
   assign level_o  = level_q;

   // R2
   wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (armed_q && target_q == $past(wr_time_i) && level_q == $past(wr_level_i)));

   // R11
   cancel_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cancel_i && !wr_i) |=> !armed_q);

   // R9
   fire_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_i && !wr_i) |=> !armed_q);

endmodule

// File: rtl/hrmatch_event_cap.sv
module hrmatch_event_cap #(
   parameter int   CNT_W    = 16,
   parameter logic PIN_INIT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire_i,
   input  logic             level_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic             match_o,
   output logic             pin_o,
   output logic [CNT_W-1:0] event_time_o
);

   logic             match_q;
   logic             pin_q;
   logic [CNT_W-1:0] evt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_q <= 1'b0;
         pin_q   <= PIN_INIT;
         evt_q   <= '0;
      end else begin
         match_q <= fire_i;
         if (fire_i) begin
            pin_q <= level_i;
            evt_q <= cnt_i;
         end
      end
   end

   assign match_o      = match_q;
   assign pin_o        = pin_q;
   assign event_time_o = evt_q;

   // R8
   pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !match_q |-> $stable(pin_q));

   // R7
   evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !match_q |-> $stable(evt_q));

   // R7
   evt_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire_i |=> (evt_q == $past(cnt_i)));

endmodule

// File: rtl/hrmatch_top.sv
module hrmatch_top
   import hrmatch_pkg::*;
#(
   parameter int         CNT_W     = 16,
   parameter logic       PIN_INIT  = 1'b0,
   parameter cmp_style_e CMP_STYLE = CMP_SUB
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             wr_i,
   input  logic [CNT_W-1:0] wr_time_i,
   input  logic             wr_level_i,
   input  logic             cancel_i,
   output logic             match_o,
   output logic             pin_o,
   output logic [CNT_W-1:0] event_time_o,
   output logic [CNT_W-1:0] match_time_o
);

   localparam int MIN_W = 4;
   localparam int MAX_W = 64;

   generate
      if (CNT_W < MIN_W || CNT_W > MAX_W) begin : g_bad_width
         $error("hrmatch_top: CNT_W out of supported range");
      end
   endgenerate

   logic             armed;
   logic [CNT_W-1:0] target;
   logic             level;
   logic             hit;
   logic             fire;

   hrmatch_arm_ctl #(.CNT_W(CNT_W)) u_arm (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (wr_i),
      .wr_time_i (wr_time_i),
      .wr_level_i(wr_level_i),
      .cancel_i  (cancel_i),
      .fire_i    (fire),
      .armed_o   (armed),
      .target_o  (target),
      .level_o   (level)
   );

   hrmatch_wrap_ge #(.CNT_W(CNT_W), .STYLE(CMP_STYLE)) u_cmp (
      .cnt_i   (cnt_i),
      .target_i(target),
      .hit_o   (hit)
   );

   // A write replaces the pending target, and a cancel suppresses it.
   assign fire = armed & hit & ~wr_i & ~cancel_i;

   hrmatch_event_cap #(.CNT_W(CNT_W), .PIN_INIT(PIN_INIT)) u_evt (
      .clk         (clk),
      .rst_n       (rst_n),
      .fire_i      (fire),
      .level_i     (level),
      .cnt_i       (cnt_i),
      .match_o     (match_o),
      .pin_o       (pin_o),
      .event_time_o(event_time_o)
   );

   assign match_time_o = target;

   // R9
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match_o |=> !match_o);

   // R10
   wr_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> !match_o);

   // R11
   cancel_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cancel_i |=> (!match_o && $stable(pin_o)));

   // R3
   match_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(match_o) |-> $past(armed && hit));

endmodule

// File: tb/hrmatch_top_tb.sv
module hrmatch_top_tb;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cnt_i = '0;
   logic        wr_i = 1'b0;
   logic [15:0] wr_time_i = '0;
   logic        wr_level_i = 1'b0;
   logic        cancel_i = 1'b0;
   logic        match_o;
   logic        pin_o;
   logic [15:0] event_time_o;
   logic [15:0] match_time_o;

   hrmatch_top u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .cnt_i       (cnt_i),
      .wr_i        (wr_i),
      .wr_time_i   (wr_time_i),
      .wr_level_i  (wr_level_i),
      .cancel_i    (cancel_i),
      .match_o     (match_o),
      .pin_o       (pin_o),
      .event_time_o(event_time_o),
      .match_time_o(match_time_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      int          cyc;
      logic [15:0] evt;
      logic        lvl;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   cyc = 0;
   int   n_chk = 0;
   int   n_err = 0;
   bit   done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Monitor: pops the expected matches and compares them with what the design produces.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (match_o) begin
            if (q.size() == 0) begin
               chk(1'b0, "R9 unexpected match", event_time_o, 16'h0);
            end else begin
               exp_t e;
               e = q.pop_front();
               chk(cyc == e.cyc, {e.tag, " cycle"}, 16'(cyc), 16'(e.cyc));
               chk(event_time_o == e.evt, {e.tag, " R7 event time"}, event_time_o, e.evt);
               chk(pin_o == e.lvl, {e.tag, " R8 pin"}, {15'h0, pin_o}, {15'h0, e.lvl});
            end
         end else if (q.size() != 0 && cyc > q[0].cyc) begin
            chk(1'b0, {q[0].tag, " missed match"}, 16'(cyc), 16'(q[0].cyc));
            void'(q.pop_front());
         end
      end
   end

   task automatic step();
      @(negedge clk);
      wr_i     = 1'b0;
      cancel_i = 1'b0;
      cnt_i    = cnt_i + 16'd1;
   endtask

   task automatic steps(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   // Driver: sets the counter to c for the write edge and predicts the match (R3).
   task automatic do_write(input logic [15:0] c, input logic [15:0] t, input logic lvl,
                           input bit cxl, input bit expect_hit, input string tag);
      logic [15:0] d1;
      logic [15:0] dk;
      int          k;
      exp_t        e;
      @(negedge clk);
      cnt_i      = c;
      wr_i       = 1'b1;
      wr_time_i  = t;
      wr_level_i = lvl;
      cancel_i   = cxl;
      d1 = c + 16'd1 - t;
      dk = t - c;
      k  = (d1 < 16'h8000) ? 1 : int'(dk);
      if (expect_hit) begin
         e.cyc = cyc + 1 + k;
         e.evt = c + 16'(k);
         e.lvl = lvl;
         e.tag = tag;
         q.push_back(e);
      end
   endtask

   task automatic drain(input string tag);
      int i;
      i = 0;
      while (q.size() != 0 && i < 40000) begin
         step();
         i++;
      end
      steps(4);
      chk(q.size() == 0, {tag, " queue drained"}, 16'(q.size()), 16'h0);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         chk(1'b0, "watchdog expired", 16'h0, 16'h0);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset values, observed while reset is held
      chk(match_o == 1'b0, "R1 match_o", {15'h0, match_o}, 16'h0);
      chk(pin_o == 1'b0, "R1 pin_o", {15'h0, pin_o}, 16'h0);
      chk(event_time_o == 16'h0, "R1 event_time_o", event_time_o, 16'h0);
      chk(match_time_o == 16'h0, "R1 match_time_o", match_time_o, 16'h0);
      rst_n = 1'b1;
      steps(3);
      chk(pin_o == 1'b0 && match_o == 1'b0, "R1 after release", {15'h0, pin_o}, 16'h0);

      // R4 target 5 counts ahead, pin goes high
      do_write(16'h0100, 16'h0105, 1'b1, 1'b0, 1'b1, "R4 ahead");
      step();
      // R2 the written value is visible as the match time
      chk(match_time_o == 16'h0105, "R2 match time", match_time_o, 16'h0105);
      drain("R4 ahead");

      // R5 stale target 0x100 behind, pin goes low
      do_write(16'h0400, 16'h0300, 1'b0, 1'b0, 1'b1, "R5 stale");
      drain("R5 stale");

      // R7 event time differs from match time (0x5E00 written, counter 0x6000 at detection)
      do_write(16'h5FFF, 16'h5E00, 1'b1, 1'b0, 1'b1, "R7 late event");
      drain("R7 late event");
      chk(match_time_o == 16'h5E00, "R7 match time kept", match_time_o, 16'h5E00);
      chk(event_time_o == 16'h6000, "R7 event time", event_time_o, 16'h6000);

      // R6 difference of 0x7FFF at the first compare fires at once
      do_write(16'h1000, 16'h1001 - 16'h7FFF, 1'b0, 1'b0, 1'b1, "R6 diff 7FFF");
      drain("R6 diff 7FFF");

      // R6 difference of 0x8000: waits until the counter reaches the target
      do_write(16'h2000, 16'hA001, 1'b1, 1'b0, 1'b1, "R6 diff 8000");
      steps(3);
      chk(match_o == 1'b0 && pin_o == 1'b0, "R6 no early fire", {15'h0, pin_o}, 16'h0);
      drain("R6 diff 8000");

      // R12 target past the wrap point
      do_write(16'hFFF0, 16'h0008, 1'b0, 1'b0, 1'b1, "R12 wrap");
      drain("R12 wrap");

      // R4 target equal to the next counter value
      do_write(16'h3000, 16'h3001, 1'b1, 1'b0, 1'b1, "R4 equal");
      drain("R4 equal");

      // R10 second write replaces the pending target; the first never fires
      do_write(16'h4000, 16'h4004, 1'b1, 1'b0, 1'b0, "R10 first");
      step();
      do_write(16'h4002, 16'h4010, 1'b0, 1'b0, 1'b1, "R10 replace");
      drain("R10 replace");
      chk(pin_o == 1'b0, "R10 pin from second write", {15'h0, pin_o}, 16'h0);

      // R11 cancel disarms; counter then runs past the target with no match
      do_write(16'h5000, 16'h5010, 1'b1, 1'b0, 1'b0, "R11 armed");
      steps(4);
      @(negedge clk);
      cancel_i = 1'b1;
      cnt_i    = cnt_i + 16'd1;
      steps(40);
      chk(pin_o == 1'b0, "R11 pin unchanged by cancel", {15'h0, pin_o}, 16'h0);
      chk(q.size() == 0, "R11 no match after cancel", 16'(q.size()), 16'h0);

      // R11 write and cancel together: the write wins and fires
      do_write(16'h6000, 16'h5FF0, 1'b1, 1'b1, 1'b1, "R11 write wins");
      drain("R11 write wins");

      // R9 a stale target keeps being stale, yet fires only once
      steps(30);
      chk(match_o == 1'b0, "R9 no refire", {15'h0, match_o}, 16'h0);
      chk(pin_o == 1'b1, "R9 pin held", {15'h0, pin_o}, 16'h1);

      finish_run();
   end

endmodule